// File: doc/BRIEF.md
# Flash Block Protection Register Controller

This block keeps the volatile block-protection byte of a serial NAND flash and decides whether a write to it is allowed. A decoded set-feature request (opcode, feature address, data byte) arrives as a one-cycle strobe. The block accepts it only when the opcode and the feature address both match. Two separate lock paths can refuse the write. The first is a hardware lock that depends on a register bit and the level of the active-low write-protect pin. The second is a one-way solid-protect bit that stays set until the next power-on reset.

The stored byte selects a protected region of a 1024-block array. A four-bit range code picks a power-of-two fraction of the array. An invert bit mirrors which end of the array the region is anchored to. A complement bit swaps protected and unprotected blocks. The block answers "protected?" combinationally for a queried block. It also screens program/erase requests: each request produces a one-cycle go pulse or a one-cycle fail pulse. While the hardware lock is active, a flag tells the I/O layer that quad transfers are unavailable.

Top module: `nand_bp_ctrl`

## Requirements
- R1: After power-on reset, the register reads 0x78. Its fields are: bit 7 = hardware-lock enable (wrlk), bits 6:3 = range code (rng), bit 2 = invert (inv), bit 1 = complement (cmp), bit 0 = solid lock (sld). So after reset the range code is all ones, the other bits are 0, lock_o and quad_dis_o are 0, and every block reads as protected.
- R2: Only a strobe with opcode 0x1F and feature address 0xA0 changes the register. A strobe with any other opcode or address leaves all 8 bits unchanged.
- R3: With no lock active, an accepted write loads bits 7:1 from the data byte and ORs data bit 0 into sld. The new value is visible from the cycle after the strobe.
- R4: The hardware lock is active exactly when wrlk=1, wr_prot_ni=0 and sld=0. While it is active, lock_o=1 and accepted writes leave bits 7:1 unchanged.
- R5: quad_dis_o is 1 exactly while the hardware lock is active. It stays 0 in solid-lock mode, even with wrlk=1 and the pin low.
- R6: A write with data bit 0 = 1 sets sld in any mode, including under the hardware lock. Once sld=1, lock_o=1, writes of 0 to sld are ignored, bits 7:1 are frozen, and only rst_ni clears it.
- R7: Range code 0 protects no block and range code 15 protects every block, before complement.
- R8: With inv=0 and cmp=0, for an array of N=1024 blocks: code k in 1..7 protects the top N>>(8-k) blocks. Code k in 8..14 protects every block except the top N>>(15-k). For example, clearing code bits 2 and 1 from reset (register 0x48, code 9) leaves only blocks 1008..1023 unprotected.
- R9: inv=1 maps block b to N-1-b before the range test, so each region is anchored at block 0 instead of block N-1.
- R10: cmp=1 inverts the protected answer for every block and every code.
- R11: A program/erase request in cycle t gives, in cycle t+1, exactly one one-cycle pulse. The pulse is op_fail_o if the requested block was protected in cycle t, and op_go_o otherwise. With no request, both stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| sf_valid_i | input | 1 | Set-feature request strobe |
| sf_opcode_i | input | 8 | Request opcode |
| sf_addr_i | input | 8 | Feature address |
| sf_data_i | input | 8 | Feature data byte |
| wr_prot_ni | input | 1 | Write-protect pin level, active low |
| qry_blk_i | input | 10 | Block address to query |
| qry_prot_o | output | 1 | Queried block is protected |
| op_valid_i | input | 1 | Program/erase request strobe |
| op_blk_i | input | 10 | Block targeted by the request |
| op_go_o | output | 1 | Request allowed (one-cycle pulse) |
| op_fail_o | output | 1 | Request rejected (one-cycle pulse) |
| reg_o | output | 8 | Current protection register byte |
| lock_o | output | 1 | Hardware or solid lock active |
| quad_dis_o | output | 1 | Quad I/O unavailable |

## Verification
The region decode is swept over all 16 range codes, combined with both invert settings and both complement settings. For each combination, every one of the 1024 block addresses is compared against an arithmetic model. A wrong fraction size shows up as an off-by-a-factor boundary, a wrong anchor shows up only under invert, and a missing complement shows up as an exact inversion of the answer. The write path is tried under three conditions: unlocked, pin-qualified hardware lock, and solid lock. Writes with the wrong opcode or wrong address tell the filter apart from the locks. Setting the solid bit while the hardware lock is active shows that the two locks hand over correctly, and that the quad flag follows only the hardware lock.

// File: rtl/nand_bp_pkg.sv
package nand_bp_pkg;
  localparam logic [7:0] SF_OPCODE = 8'h1F;
  localparam logic [7:0] SF_ADDR   = 8'hA0;
  localparam int unsigned RNG_W    = 4;

  typedef struct packed {
    logic             wrlk;
    logic [RNG_W-1:0] rng;
    logic             inv;
    logic             cmp;
    logic             sld;
  } bp_reg_t;

  localparam bp_reg_t BP_RESET = '{wrlk: 1'b0, rng: '1, inv: 1'b0, cmp: 1'b0, sld: 1'b0};
endpackage

// File: rtl/nand_bp_regfile.sv
module nand_bp_regfile
  import nand_bp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sf_valid_i,
  input  logic [7:0] sf_opcode_i,
  input  logic [7:0] sf_addr_i,
  input  logic [7:0] sf_data_i,
  input  logic       wr_prot_ni,
  output bp_reg_t    reg_o,
  output logic       lock_o,
  output logic       hw_lock_o
);
  bp_reg_t reg_q, wdata;
  logic    wr_hit;

  assign wdata     = bp_reg_t'(sf_data_i);
  assign wr_hit    = sf_valid_i && (sf_opcode_i == SF_OPCODE) && (sf_addr_i == SF_ADDR);
  assign hw_lock_o = reg_q.wrlk && !wr_prot_ni && !reg_q.sld;
  assign lock_o    = hw_lock_o || reg_q.sld;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_q <= BP_RESET;
    end else if (wr_hit) begin
      if (!lock_o) begin
        reg_q.wrlk <= wdata.wrlk;
        reg_q.rng  <= wdata.rng;
        reg_q.inv  <= wdata.inv;
        reg_q.cmp  <= wdata.cmp;
      end
      // sticky: only power-on reset clears it
      reg_q.sld <= reg_q.sld | wdata.sld;
    end
  end

  assign reg_o = reg_q;

  p_filter_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sf_valid_i && (sf_opcode_i != SF_OPCODE || sf_addr_i != SF_ADDR)) |=> $stable(reg_q));
  p_frozen_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o |=> $stable(reg_q[7:1]));
  p_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_q.sld |=> reg_q.sld);
endmodule

// File: rtl/nand_bp_decode.sv
module nand_bp_decode
  import nand_bp_pkg::*;
#(
  parameter int unsigned BLK_AW = 10  // must be >= 2**(RNG_W-1)-1
) (
  input  bp_reg_t           reg_i,
  input  logic [BLK_AW-1:0] blk_i,
  output logic              prot_o
);
  localparam int unsigned NSTEP   = (1 << (RNG_W - 1)) - 1;
  localparam int unsigned RNG_ALL = (1 << RNG_W) - 1;

  logic [BLK_AW-1:0] addr_m;
  logic [NSTEP:1]    top_ones;
  logic              in_rng;
  int                code;

  assign addr_m = reg_i.inv ? ~blk_i : blk_i;
  assign code   = int'(reg_i.rng);

  // top_ones[j]: block lies in the top N>>j blocks
  for (genvar j = 1; j <= NSTEP; j++) begin : g_top
    assign top_ones[j] = &addr_m[BLK_AW-1 -: j];
  end

  always_comb begin
    in_rng = 1'b0;
    if (code == int'(RNG_ALL)) in_rng = 1'b1;
    for (int j = 1; j <= NSTEP; j++) begin
      if (code == int'(NSTEP) + 1 - j)     in_rng = top_ones[j];
      if (code == 2 * int'(NSTEP) + 1 - j) in_rng = ~top_ones[j];
    end
  end

  assign prot_o = in_rng ^ reg_i.cmp;
endmodule

// File: rtl/nand_bp_opgate.sv
module nand_bp_opgate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic op_valid_i,
  input  logic prot_i,
  output logic op_go_o,
  output logic op_fail_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_go_o   <= 1'b0;
      op_fail_o <= 1'b0;
    end else begin
      op_go_o   <= op_valid_i && !prot_i;
      op_fail_o <= op_valid_i && prot_i;
    end
  end

  p_one_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i |=> (op_go_o ^ op_fail_o));
  p_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_valid_i |=> !(op_go_o || op_fail_o));
endmodule

// File: rtl/nand_bp_ctrl.sv
module nand_bp_ctrl
  import nand_bp_pkg::*;
#(
  parameter int unsigned BLK_AW = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sf_valid_i,
  input  logic [7:0]        sf_opcode_i,
  input  logic [7:0]        sf_addr_i,
  input  logic [7:0]        sf_data_i,
  input  logic              wr_prot_ni,
  input  logic [BLK_AW-1:0] qry_blk_i,
  output logic              qry_prot_o,
  input  logic              op_valid_i,
  input  logic [BLK_AW-1:0] op_blk_i,
  output logic              op_go_o,
  output logic              op_fail_o,
  output logic [7:0]        reg_o,
  output logic              lock_o,
  output logic              quad_dis_o
);
  bp_reg_t cur;
  logic    hw_lock, op_prot;

  nand_bp_regfile u_reg (
    .clk_i, .rst_ni, .sf_valid_i, .sf_opcode_i, .sf_addr_i, .sf_data_i, .wr_prot_ni,
    .reg_o(cur), .lock_o, .hw_lock_o(hw_lock)
  );

  nand_bp_decode #(.BLK_AW(BLK_AW)) u_dec_qry (.reg_i(cur), .blk_i(qry_blk_i), .prot_o(qry_prot_o));
  nand_bp_decode #(.BLK_AW(BLK_AW)) u_dec_op  (.reg_i(cur), .blk_i(op_blk_i),  .prot_o(op_prot));

  nand_bp_opgate u_gate (
    .clk_i, .rst_ni, .op_valid_i, .prot_i(op_prot), .op_go_o, .op_fail_o
  );

  assign reg_o      = cur;
  assign quad_dis_o = hw_lock;

  p_quad_solid_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur.sld |-> !quad_dis_o);
  p_all_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&cur.rng && !cur.cmp) |-> qry_prot_o);
  p_none_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur.rng == '0 && !cur.cmp) |-> !qry_prot_o);
  p_cmp_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&cur.rng && cur.cmp) |-> !qry_prot_o);
endmodule

// File: tb/nand_bp_ctrl_tb_top.sv
module nand_bp_ctrl_tb_top;
  localparam int N = 1024;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sf_valid = 1'b0;
  logic [7:0] sf_op = '0, sf_addr = '0, sf_data = '0;
  logic       wp_n = 1'b1;
  logic [9:0] qry_blk = '0, op_blk = '0;
  logic       op_valid = 1'b0;
  logic       qry_prot, op_go, op_fail, lock, quad_dis;
  logic [7:0] regv;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #4 clk = ~clk;

  nand_bp_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sf_valid_i(sf_valid), .sf_opcode_i(sf_op),
    .sf_addr_i(sf_addr), .sf_data_i(sf_data), .wr_prot_ni(wp_n),
    .qry_blk_i(qry_blk), .qry_prot_o(qry_prot), .op_valid_i(op_valid),
    .op_blk_i(op_blk), .op_go_o(op_go), .op_fail_o(op_fail), .reg_o(regv),
    .lock_o(lock), .quad_dis_o(quad_dis)
  );

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic bit model_prot(logic [7:0] r, int blk);
    int code = int'(r[6:3]);
    int b = r[2] ? N - 1 - blk : blk;
    bit p;
    if (code == 0) p = 0;
    else if (code == 15) p = 1;
    else if (code <= 7) p = (b >= N - (N >> (8 - code)));
    else p = (b < N - (N >> (15 - code)));
    return p ^ r[1];
  endfunction

  task automatic sf_write(logic [7:0] op, logic [7:0] addr, logic [7:0] data);
    @(negedge clk);
    sf_valid = 1'b1; sf_op = op; sf_addr = addr; sf_data = data;
    @(negedge clk);
    sf_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1", "reg", regv, 8'h78);
    check("R1", "lock", lock, 0);
    check("R1", "quad_dis", quad_dis, 0);
    qry_blk = 10'd0;   #1; check("R1", "prot blk0", qry_prot, 1);
    qry_blk = 10'd1023; #1; check("R1", "prot blk1023", qry_prot, 1);
  endtask

  task automatic t_filter();
    sf_write(8'h0F, 8'hA0, 8'h00); check("R2", "wrong opcode", regv, 8'h78);
    sf_write(8'h1F, 8'hB0, 8'h00); check("R2", "wrong address", regv, 8'h78);
    sf_write(8'h1F, 8'hA0, 8'h48); check("R2", "matching write", regv, 8'h48);
  endtask

  task automatic t_unlocked();
    sf_write(8'h1F, 8'hA0, 8'h56); check("R3", "all fields", regv, 8'h56);
    sf_write(8'h1F, 8'hA0, 8'h48);
    qry_blk = 10'd1007; #1; check("R8", "code9 blk1007", qry_prot, 1);
    qry_blk = 10'd1008; #1; check("R8", "code9 blk1008", qry_prot, 0);
  endtask

  task automatic t_decode_sweep();
    for (int v = 0; v < 64; v++) begin
      logic [7:0] r = {1'b0, v[3:0], v[4], v[5], 1'b0};
      int bad = 0;
      sf_write(8'h1F, 8'hA0, r);
      for (int b = 0; b < N; b++) begin
        qry_blk = b[9:0]; #1;
        if (qry_prot != model_prot(r, b)) bad++;
      end
      if (!r[2] && !r[1]) check("R8", $sformatf("sweep reg=%02h mismatches", r), bad, 0);
      else if (r[2] && !r[1]) check("R9", $sformatf("sweep reg=%02h mismatches", r), bad, 0);
      else check("R10", $sformatf("sweep reg=%02h mismatches", r), bad, 0);
      if (r[6:3] == 4'd0 || r[6:3] == 4'd15)
        check("R7", $sformatf("edge code reg=%02h mismatches", r), bad, 0);
    end
  endtask

  task automatic t_hw_lock();
    wp_n = 1'b1;
    sf_write(8'h1F, 8'hA0, 8'hC8); check("R4", "wrlk set while pin high", regv, 8'hC8);
    check("R4", "no lock with pin high", lock, 0);
    wp_n = 1'b0; #1;
    check("R4", "lock with pin low", lock, 1);
    check("R5", "quad off in hw lock", quad_dis, 1);
    sf_write(8'h1F, 8'hA0, 8'h00); check("R4", "write ignored", regv, 8'hC8);
    wp_n = 1'b1; #1;
    check("R5", "quad back on", quad_dis, 0);
    sf_write(8'h1F, 8'hA0, 8'h48); check("R4", "write after release", regv, 8'h48);
  endtask

  task automatic t_ops();
    // reg 0x48: blocks 1008..1023 free
    @(negedge clk); op_valid = 1'b1; op_blk = 10'd5;
    @(posedge clk); #1;
    check("R11", "fail on protected", op_fail, 1); check("R11", "no go on protected", op_go, 0);
    @(negedge clk); op_blk = 10'd1010;
    @(posedge clk); #1;
    check("R11", "go on free", op_go, 1); check("R11", "no fail on free", op_fail, 0);
    @(negedge clk); op_valid = 1'b0;
    @(posedge clk); #1;
    check("R11", "idle go", op_go, 0); check("R11", "idle fail", op_fail, 0);
    check("R11", "reg untouched", regv, 8'h48);
  endtask

  task automatic t_solid();
    sf_write(8'h1F, 8'hA0, 8'hC8);
    wp_n = 1'b0; #1; check("R4", "hw lock before sld", lock, 1);
    sf_write(8'h1F, 8'hA0, 8'h01); check("R6", "sld set under hw lock", regv, 8'hC9);
    check("R6", "solid lock", lock, 1);
    check("R5", "quad on in solid", quad_dis, 0);
    wp_n = 1'b1; #1;
    sf_write(8'h1F, 8'hA0, 8'h00); check("R6", "sld sticky, fields frozen", regv, 8'hC9);
    check("R6", "lock with pin high", lock, 1);
    do_reset();
    check("R6", "reset leaves solid", regv, 8'h78);
    check("R6", "unlocked after reset", lock, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_filter();
    t_unlocked();
    t_decode_sweep();
    t_hw_lock();
    t_ops();
    t_solid();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  end
endmodule